// File: doc/BRIEF.md
# PHY Management Bus Controller

This block lets software reach the management registers of an Ethernet PHY over the two-wire serial management bus (MDC clock plus bidirectional MDIO data). Software sees two 32-bit registers. The command register holds a PHY address, a register number and two self-clearing command flags. The data register holds the value a write transaction will send.

Setting a command flag makes the block clock out one complete clause-22 frame on MDC/MDIO. Bits go out most significant first, in this order: 32 preamble ones, start `01`, the opcode (`10` read, `01` write), PHY address, register number, a two-bit turnaround, and 16 data bits. The flag stays set while the frame is on the wire and clears when the frame ends. Software polls that flag. After a read it finds the result in the low half of the same register.

The register port has no handshake. A write is a single-cycle strobe, and the read data is a combinational view of the selected register. Timeouts, PHY discovery and link policy are left to software.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, both registers read zero, MDC is low and the MDIO output enable is low.
- R2: Writing the command register (select 0) with bit 27 set performs a write frame. On the wire, in order: 32 ones, `01`, `01`, the 5-bit PHY address, the 5-bit register number, turnaround `10`, then data register bits 15:0. Each field is sent MSB first.
- R3: Writing the command register with bit 26 set performs a read frame with opcode `10`. The 16 bits received after the turnaround, sampled at MDC rising edges and MSB first, appear in command register bits 15:0 once bit 26 has cleared.
- R4: The PHY address is taken from command bits 20:16 and the register number from bits 25:21. Both fields read back as written. Bits 31:28 always read zero.
- R5: A command bit reads as set from the cycle after it is written until its frame ends, and reads as clear afterwards.
- R6: A read with no PHY driving the line returns 0xFFFF, because the bus idles high.
- R7: MDC has a period of 2*DIV_HALF system clocks during a frame and stays low while idle. The MDIO output changes only while MDC is low.
- R8: During a read, the output enable is low from the first turnaround bit to the end of the frame.
- R9: A command register write while a frame is in progress is ignored. Fields and flags keep their values and the frame on the wire is unchanged.
- R10: A command word with both bits 26 and 27 set performs a read, and only bit 26 reads back as set.
- R11: The data register (select 1) reads back all 32 bits as written and can be written at any time. A write to it during a frame does not alter the frame already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| mdc | output | 1 | Management bus clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value, pulled high externally |

## Verification
The assertions check properties that must hold on every cycle. MDIO changes only while MDC is low. MDC is parked low whenever no command is pending. At most one command flag is set at any time. The output enable is released through the read turnaround and data. The address fields stay frozen while a frame runs. The bench's scenarios are needed to show the bit-exact frame contents, the captured read value, the all-ones result with no PHY present, the MDC period, and the fact that a data-register update part-way through a frame leaves that frame's payload untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int FIELD_W    = 5;
  localparam int DATA_W     = 16;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  // command register layout (software visible)
  localparam int RD_BIT     = 26;
  localparam int WR_BIT     = 27;
  localparam int PHY_LSB    = 16;
  localparam int REG_LSB    = 21;
  // frame bit indices, counted from the first preamble bit
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef struct packed {
    logic               wr;
    logic               rd;
    logic [FIELD_W-1:0] regn;
    logic [FIELD_W-1:0] phy;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last  = run && (cnt == LAST);
  assign rise_stb = at_last && !mdc;
  assign fall_stb = at_last && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_rd,
  input  logic [FIELD_W-1:0] phy,
  input  logic [FIELD_W-1:0] regn,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rise_stb,
  input  logic               fall_stb,
  input  logic               mdio_i,
  output logic               run,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  output logic [IDX_W-1:0]   bit_idx
);
  logic [FRAME_BITS-1:0] shreg;
  logic                  is_rd;
  logic [FRAME_BITS-1:0] frame_word;

  assign frame_word = {{PRE_BITS{1'b1}}, 2'b01,
                       (start_rd ? 2'b10 : 2'b01), phy, regn,
                       (start_rd ? 2'b11 : 2'b10),
                       (start_rd ? {DATA_W{1'b1}} : wdata)};

  assign done   = fall_stb && (bit_idx == IDX_W'(FRAME_BITS - 1));
  assign mdio_o = run ? shreg[FRAME_BITS-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      is_rd   <= 1'b0;
      run     <= 1'b0;
      mdio_oe <= 1'b0;
      bit_idx <= '0;
      rdata   <= '0;
    end else if (!run) begin
      if (start) begin
        shreg   <= frame_word;
        is_rd   <= start_rd;
        run     <= 1'b1;
        mdio_oe <= 1'b1;
        bit_idx <= '0;
      end
    end else begin
      if (rise_stb && is_rd && (bit_idx >= IDX_W'(DATA_FIRST)))
        rdata <= {rdata[DATA_W-2:0], mdio_i};
      if (done) begin
        run     <= 1'b0;
        mdio_oe <= 1'b0;
      end else if (fall_stb) begin
        shreg   <= shreg << 1;
        bit_idx <= bit_idx + 1'b1;
        if (is_rd && (bit_idx == IDX_W'(TA_FIRST - 1)))
          mdio_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata,
  output mdio_cmd_t         cmd,
  output logic [31:0]       data_q,
  output logic              busy,
  output logic              start,
  output logic              start_rd
);
  logic [DATA_W-1:0] result;

  assign busy     = cmd.rd | cmd.wr;
  assign start_rd = reg_wdata[RD_BIT];
  assign start    = reg_we && !reg_sel && !busy &&
                    (reg_wdata[RD_BIT] | reg_wdata[WR_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd    <= '0;
      data_q <= '0;
      result <= '0;
    end else begin
      if (reg_we && reg_sel)
        data_q <= reg_wdata;
      if (reg_we && !reg_sel && !busy) begin
        cmd.rd   <= reg_wdata[RD_BIT];
        cmd.wr   <= reg_wdata[WR_BIT] & ~reg_wdata[RD_BIT];
        cmd.regn <= reg_wdata[REG_LSB +: FIELD_W];
        cmd.phy  <= reg_wdata[PHY_LSB +: FIELD_W];
      end else if (done) begin
        cmd.rd <= 1'b0;
        cmd.wr <= 1'b0;
        if (cmd.rd)
          result <= rdata;
      end
    end
  end

  always_comb begin
    if (reg_sel)
      reg_rdata = data_q;
    else
      reg_rdata = {4'b0, cmd.wr, cmd.rd, cmd.regn, cmd.phy, result};
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t         cmd_q;
  logic [31:0]       data_q;
  logic              busy, start, start_rd, run, rise_stb, fall_stb;
  logic              frame_done;
  logic [DATA_W-1:0] rx_data;
  logic [IDX_W-1:0]  bit_idx;
  logic              cmd_rd, cmd_wr;
  logic [9:0]        cmd_fields;

  assign cmd_rd     = cmd_q.rd;
  assign cmd_wr     = cmd_q.wr;
  assign cmd_fields = {cmd_q.regn, cmd_q.phy};

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(frame_done),
    .rdata(rx_data), .cmd(cmd_q), .data_q(data_q), .busy(busy),
    .start(start), .start_rd(start_rd)
  );

  mdio_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .mdc(mdc),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
    .phy(reg_wdata[PHY_LSB +: FIELD_W]), .regn(reg_wdata[REG_LSB +: FIELD_W]),
    .wdata(data_q[DATA_W-1:0]), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .mdio_i(mdio_i), .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(frame_done), .rdata(rx_data), .bit_idx(bit_idx)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       cmd_rd,
  input logic       cmd_wr,
  input logic       frame_done,
  input logic [5:0] bit_idx,
  input logic [9:0] cmd_fields
);
  // R7: data changes only while MDC is low
  p_mdio_change_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);
  // R7: MDC parked low when idle
  p_mdc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R8: driver released during read turnaround and data
  p_ta_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && bit_idx >= 6'd46) |-> !mdio_oe);
  // R9: fields frozen while a frame runs
  p_fields_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> $stable(cmd_fields));
  // R10: never both command flags
  p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_rd, cmd_wr}));
  // R5: flag clears after frame end
  p_clear_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .frame_done(frame_done),
  .bit_idx(bit_idx), .cmd_fields(cmd_fields)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int DIV_HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_present = 1'b1;
  logic        phy_drv = 1'b0, phy_bit = 1'b1;
  logic [15:0] phy_val = 16'h0;
  int          rise_k = 0;
  logic [63:0] wire_bits = '0;
  logic        ta_bad = 1'b0;
  int          cyc = 0;
  int          n_chk = 0, n_fail = 0;

  typedef struct {
    logic        is_rd;
    logic [63:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // PHY model: capture line on MDC rise
  always @(posedge mdc) begin
    if (rise_k < 64) wire_bits[63-rise_k] = mdio_i;
    if ((rise_k == 46 || rise_k == 47) && wire_bits[29] && !wire_bits[28] && mdio_oe)
      ta_bad = 1'b1;
    rise_k++;
  end

  // PHY drive on MDC fall, and scoreboard monitor at frame end
  always @(negedge mdc) begin
    phy_drv = phy_present && wire_bits[29] && !wire_bits[28] &&
              rise_k >= 47 && rise_k <= 63;
    phy_bit = (rise_k == 47) ? 1'b0 : phy_val[(rise_k >= 48 && rise_k <= 63) ? 63 - rise_k : 0];
    if (rise_k == 64) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 scoreboard empty", 64'd0, 64'd1);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.is_rd) begin
          chk(wire_bits[63:18] == it.exp[63:18], it.req, {18'd0, wire_bits[63:18]},
              {18'd0, it.exp[63:18]});
          chk(!ta_bad, "R8 oe low in turnaround", {63'd0, ta_bad}, 64'd0);
        end else begin
          chk(wire_bits == it.exp, it.req, wire_bits, it.exp);
        end
      end
      ta_bad = 1'b0;
    end
  end

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic rd, input logic wr,
                                           input logic [4:0] p, input logic [4:0] r);
    return {4'b0, wr, rd, r, p, 16'h0};
  endfunction

  task automatic push_wr(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d,
                         input string req);
    item_t it;
    it.is_rd = 1'b0;
    it.exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic push_rd(input logic [4:0] p, input logic [4:0] r, input string req);
    item_t it;
    it.is_rd = 1'b1;
    it.exp = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h0};
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic wait_idle(output logic [31:0] v);
    do rd_reg(1'b0, v); while (v[27] | v[26]);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      begin : main
        logic [31:0] v;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(1'b0, v); chk(v == 32'h0, "R1 command reg reset", v, 0);
        rd_reg(1'b1, v); chk(v == 32'h0, "R1 data reg reset", v, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 bus idle", {mdc, mdio_oe}, 0);

        // R11 data register readback
        wr_reg(1'b1, 32'h5EED_A5C3);
        rd_reg(1'b1, v); chk(v == 32'h5EED_A5C3, "R11 data readback", v, 32'h5EED_A5C3);

        // R2/R4 write frame
        rise_k = 0;
        push_wr(5'h11, 5'h0A, 16'hA5C3, "R2 R4 write frame bits");
        wr_reg(1'b0, cmd_word(0, 1, 5'h11, 5'h0A));
        rd_reg(1'b0, v); chk(v[27] == 1'b1, "R5 write flag set", v, 32'h0800_0000);
        @(posedge mdc); t0 = cyc;
        @(posedge mdc);
        chk(cyc - t0 == 2 * DIV_HALF, "R7 MDC period", 64'(cyc - t0), 64'(2 * DIV_HALF));
        wait_idle(v);
        chk(v[27:26] == 2'b00, "R5 flags cleared", v, 0);
        chk(v[25:16] == {5'h0A, 5'h11}, "R4 fields readback", v[25:16], {5'h0A, 5'h11});
        chk(mdc == 1'b0, "R7 MDC low idle", mdc, 0);

        // R3 read with PHY present
        rise_k = 0; phy_present = 1'b1; phy_val = 16'h1234;
        push_rd(5'h03, 5'h01, "R3 read frame header");
        wr_reg(1'b0, cmd_word(1, 0, 5'h03, 5'h01));
        rd_reg(1'b0, v); chk(v[26] == 1'b1, "R5 read flag set", v, 32'h0400_0000);
        wait_idle(v);
        chk(v[15:0] == 16'h1234, "R3 read data", v[15:0], 16'h1234);
        chk(v[31:28] == 4'h0, "R4 upper bits zero", v[31:28], 0);

        // R6 no PHY
        rise_k = 0; phy_present = 1'b0;
        push_rd(5'h1F, 5'h02, "R6 read frame header");
        wr_reg(1'b0, cmd_word(1, 0, 5'h1F, 5'h02));
        wait_idle(v);
        chk(v[15:0] == 16'hFFFF, "R6 absent PHY all ones", v[15:0], 16'hFFFF);

        // R9/R11 writes during a frame
        rise_k = 0; phy_present = 1'b1;
        wr_reg(1'b1, 32'h0000_C0DE);
        push_wr(5'h01, 5'h02, 16'hC0DE, "R9 R11 frame unaltered");
        wr_reg(1'b0, cmd_word(0, 1, 5'h01, 5'h02));
        repeat (40) @(negedge clk);
        wr_reg(1'b0, cmd_word(1, 0, 5'h07, 5'h09));
        wr_reg(1'b1, 32'h0000_BAD0);
        rd_reg(1'b0, v);
        chk(v[27:16] == {2'b10, 5'h02, 5'h01}, "R9 command ignored while busy",
            v[27:16], {2'b10, 5'h02, 5'h01});
        rd_reg(1'b1, v); chk(v == 32'h0000_BAD0, "R11 data write while busy", v, 32'hBAD0);
        wait_idle(v);

        // R10 both bits set
        rise_k = 0; phy_val = 16'hBEEF;
        push_rd(5'h02, 5'h04, "R10 read frame header");
        wr_reg(1'b0, cmd_word(1, 1, 5'h02, 5'h04));
        rd_reg(1'b0, v); chk(v[27:26] == 2'b01, "R10 only read flag", v[27:26], 2'b01);
        wait_idle(v);
        chk(v[15:0] == 16'hBEEF, "R10 read data", v[15:0], 16'hBEEF);
        chk(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
      end
      begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule